// File: doc/BRIEF.md
# Adaptive slope beat and complex-boundary marker

This block watches a stream of unsigned ECG samples (one accepted sample per cycle in which the valid input is high, nominally 1 kHz). It takes the first difference of the stream and smooths it with a running sum over a short window. It flags a heartbeat when the magnitude of that smoothed slope reaches an adaptive threshold. The threshold is half of a peak tracker that follows the slope magnitude upward at once and lets it sink slowly, so detection follows the steepness of the waves rather than their absolute height. A refractory interval after each beat stops one complex from being reported twice.

Alongside beat detection the block marks where a complex begins and ends. An onset is reported when either of two slope patterns appears: two large steps of the same direction close together, or a large positive and a large negative smoothed excursion within a longer window (this catches slow waves). Once an onset has been reported, the block waits for the signal to go flat over a fixed window of samples and then reports an offset. After the offset, a new onset may be reported. Each of the three events leaves the block as a one-cycle strobe with the index of the sample that caused it.

Top module: `slope_beat_detector`

## Requirements
- R1: While `rst_n` is low, and after reset until samples arrive, all three strobes are 0. Reset clears the sample index to 0, the peak tracker to 0, the refractory count to 0, the onset/offset state to "ready for onset", and all sample and step history to 0.
- R2: For accepted sample n, the slope is d[n] = x[n] − x[n−1], and the smoothed slope s[n] is the sum of d[n−AVG+1..n]. Samples before reset count as 0. The smoothed-slope magnitude is |s[n]|, and |s[n]| never exceeds 2^XW − 1.
- R3: A beat is flagged at sample n when three conditions all hold: the threshold T = P/2 (integer halving of the peak value P held before sample n) satisfies T ≥ MIN_THR, |s[n]| ≥ T (equality counts), and the sample is not refractory.
- R4: After each accepted sample, P becomes the larger of |s[n]| and P − floor(P / 2^DSH).
- R5: After a beat at sample n, samples n+1 through n+REFRAC can never produce a beat. Sample n+REFRAC+1 may produce one.
- R6: Onset rule one: d[n] is a large step when d[n] ≥ BIG or d[n] ≤ −BIG. The rule fires at a large step whose direction matches the most recent earlier large step, when the two sample indices differ by less than W1.
- R7: Onset rule two: s[n] is a large excursion when s[n] ≥ HIGH or s[n] ≤ −HIGH. The rule fires at a large excursion when the most recent earlier large excursion of the opposite sign lies fewer than W2 samples before it.
- R8: An onset is reported only when the block is ready for an onset. Reporting an onset clears readiness, so further rule hits are ignored (no onset strobe) until an offset has been reported.
- R9: A sample n is flat when n ≥ FLATW−1 and the largest minus the smallest of x[n−FLATW+1..n] is less than FLAT_LSB. An offset is reported at a flat sample when the block is not ready for an onset, and reporting it restores readiness.
- R10: Strobes rise in the cycle after the valid input that carries the sample causing the event. Each strobe lasts one cycle, and its index output holds n. Cycles without valid input produce no strobe and do not advance the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_vld | input | 1 | Sample on `samp` is accepted this cycle |
| samp | input | XW | Unsigned ECG sample |
| beat_stb | output | 1 | Beat detected (one cycle) |
| beat_idx | output | IDXW | Index of the sample that triggered the beat |
| onset_stb | output | 1 | Complex onset marked (one cycle) |
| onset_idx | output | IDXW | Index of the onset sample |
| offset_stb | output | 1 | Complex offset marked (one cycle) |
| offset_idx | output | IDXW | Index of the offset sample |

## Verification
The bench builds the block with AVG=8, DSH=3, MIN_THR=40, REFRAC=10, BIG=60, W1=6, HIGH=150, W2=20, FLATW=8, FLAT_LSB=5 and IDXW=12. With windows this short, the refractory limit, the step-gap boundaries either side of W1, and the excursion gaps either side of W2 are each reached many times within a few thousand samples. The same short windows make flat windows both just under and just over the flatness limit. Every accepted sample is compared against a reference that recomputes differences, sums and window ranges directly from the stored sample array. Idle cycles are interleaved to confirm that no event or index advance occurs without a valid sample.

// File: rtl/qrs_pkg.sv
package qrs_pkg;
  typedef enum logic {SGN_POS = 1'b0, SGN_NEG = 1'b1} sgn_e;
endpackage

// File: rtl/slope_front.sv
module slope_front #(
  parameter int XW  = 12,
  parameter int AVG = 8,
  localparam int DW = XW + 1,
  localparam int SW = DW + $clog2(AVG)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 vld,
  input  logic [XW-1:0]        x,
  output logic signed [DW-1:0] d,
  output logic signed [SW-1:0] s
);
  localparam logic signed [SW-1:0] XMAX = SW'((1 << XW) - 1);

  logic [XW-1:0]        x_prev;
  logic signed [DW-1:0] dh [AVG];
  logic signed [SW-1:0] sum_q;

  function automatic logic signed [DW-1:0] step_of(input logic [XW-1:0] cur,
                                                    input logic [XW-1:0] prv);
    return $signed({1'b0, cur}) - $signed({1'b0, prv});
  endfunction

  assign d = step_of(x, x_prev);
  assign s = sum_q + SW'(d) - SW'(dh[AVG-1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_prev <= '0;
      sum_q  <= '0;
      for (int i = 0; i < AVG; i++) dh[i] <= '0;
    end else if (vld) begin
      x_prev <= x;
      sum_q  <= s;
      dh[0]  <= d;
      for (int i = 1; i < AVG; i++) dh[i] <= dh[i-1];
    end
  end

  // R2: the running sum telescopes to x[n]-x[n-AVG], so it stays in sample range
  a_r2_slope_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (s <= XMAX) && (s >= -XMAX));
endmodule

// File: rtl/beat_gate.sv
module beat_gate #(
  parameter int MW      = 16,
  parameter int DSH     = 3,
  parameter int MIN_THR = 64,
  parameter int REFRAC  = 200,
  localparam int RCW    = $clog2(REFRAC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld,
  input  logic [MW-1:0] mag,
  output logic          hit
);
  logic [MW-1:0]  peak_q, thr, decayed, peak_nx;
  logic [RCW-1:0] rc_q;
  logic           refr;

  function automatic logic [MW-1:0] decay_of(input logic [MW-1:0] p);
    return p - (p >> DSH);
  endfunction

  assign thr     = peak_q >> 1;
  assign decayed = decay_of(peak_q);
  assign peak_nx = (mag > decayed) ? mag : decayed;
  assign refr    = (rc_q != '0);
  assign hit     = vld && !refr && (thr >= MW'(MIN_THR)) && (mag >= thr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      peak_q <= '0;
      rc_q   <= '0;
    end else if (vld) begin
      peak_q <= peak_nx;
      if (hit)       rc_q <= RCW'(REFRAC);
      else if (refr) rc_q <= rc_q - RCW'(1);
    end
  end

  // R4: the tracker never falls below the magnitude just seen
  a_r4_peak_covers_mag: assert property (@(posedge clk) disable iff (!rst_n)
    vld |=> (peak_q >= $past(mag)));
endmodule

// File: rtl/flat_finder.sv
module flat_finder #(
  parameter int XW       = 12,
  parameter int FLATW    = 40,
  parameter int FLAT_LSB = 8,
  localparam int FCW     = $clog2(FLATW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld,
  input  logic [XW-1:0] x,
  output logic          flat
);
  logic [XW-1:0]  win [FLATW-1];
  logic [FCW-1:0] fill_q;
  logic [XW-1:0]  mx, mn;

  always_comb begin
    mx = x;
    mn = x;
    for (int i = 0; i < FLATW - 1; i++) begin
      if (win[i] > mx) mx = win[i];
      if (win[i] < mn) mn = win[i];
    end
  end

  assign flat = (fill_q == FCW'(FLATW - 1)) && ((mx - mn) < XW'(FLAT_LSB));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_q <= '0;
      for (int i = 0; i < FLATW - 1; i++) win[i] <= '0;
    end else if (vld) begin
      if (fill_q != FCW'(FLATW - 1)) fill_q <= fill_q + FCW'(1);
      win[0] <= x;
      for (int i = 1; i < FLATW - 1; i++) win[i] <= win[i-1];
    end
  end
endmodule

// File: rtl/onset_marker.sv
module onset_marker #(
  parameter int DW   = 13,
  parameter int SW   = 16,
  parameter int IDXW = 16,
  parameter int BIG  = 40,
  parameter int HIGH = 400,
  parameter int W1   = 40,
  parameter int W2   = 240
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 vld,
  input  logic signed [DW-1:0] d,
  input  logic signed [SW-1:0] s,
  input  logic [IDXW-1:0]      idx,
  input  logic                 flat,
  output logic                 c1,
  output logic                 c2,
  output logic                 onset_hit,
  output logic                 offset_hit
);
  import qrs_pkg::*;

  localparam logic signed [DW-1:0] BIG_P  = DW'(BIG);
  localparam logic signed [SW-1:0] HIGH_P = SW'(HIGH);

  logic            st_v, xp_v, xn_v, armed_q;
  sgn_e            st_sgn, cur_sgn;
  logic [IDXW-1:0] st_idx, xp_idx, xn_idx, gap1, gapp, gapn;
  logic            big, ex_pos, ex_neg;

  function automatic logic near(input logic [IDXW-1:0] gap, input int win);
    return gap < IDXW'(win);
  endfunction

  assign big     = (d >= BIG_P) || (d <= -BIG_P);
  assign cur_sgn = d[DW-1] ? SGN_NEG : SGN_POS;
  assign ex_pos  = (s >= HIGH_P);
  assign ex_neg  = (s <= -HIGH_P);
  assign gap1    = idx - st_idx;
  assign gapp    = idx - xp_idx;
  assign gapn    = idx - xn_idx;

  assign c1 = big && st_v && (st_sgn == cur_sgn) && near(gap1, W1);
  assign c2 = (ex_pos && xn_v && near(gapn, W2)) ||
              (ex_neg && xp_v && near(gapp, W2));

  assign onset_hit  = vld && armed_q && (c1 || c2);
  assign offset_hit = vld && !armed_q && flat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_v    <= 1'b0;
      st_sgn  <= SGN_POS;
      st_idx  <= '0;
      xp_v    <= 1'b0;
      xp_idx  <= '0;
      xn_v    <= 1'b0;
      xn_idx  <= '0;
      armed_q <= 1'b1;
    end else if (vld) begin
      if (big) begin
        st_v   <= 1'b1;
        st_sgn <= cur_sgn;
        st_idx <= idx;
      end
      if (ex_pos) begin
        xp_v   <= 1'b1;
        xp_idx <= idx;
      end
      if (ex_neg) begin
        xn_v   <= 1'b1;
        xn_idx <= idx;
      end
      if (onset_hit)       armed_q <= 1'b0;
      else if (offset_hit) armed_q <= 1'b1;
    end
  end

  // R7: an excursion rule hit needs an earlier opposite excursion on record
  a_r7_excursion_has_partner: assert property (@(posedge clk) disable iff (!rst_n)
    c2 |-> (xp_v || xn_v));
endmodule

// File: rtl/slope_beat_detector.sv
module slope_beat_detector #(
  parameter int XW       = 12,
  parameter int AVG      = 8,
  parameter int IDXW     = 16,
  parameter int DSH      = 3,
  parameter int MIN_THR  = 64,
  parameter int REFRAC   = 200,
  parameter int BIG      = 40,
  parameter int W1       = 40,
  parameter int HIGH     = 400,
  parameter int W2       = 240,
  parameter int FLATW    = 40,
  parameter int FLAT_LSB = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            samp_vld,
  input  logic [XW-1:0]   samp,
  output logic            beat_stb,
  output logic [IDXW-1:0] beat_idx,
  output logic            onset_stb,
  output logic [IDXW-1:0] onset_idx,
  output logic            offset_stb,
  output logic [IDXW-1:0] offset_idx
);
  localparam int DW = XW + 1;
  localparam int SW = DW + $clog2(AVG);

  logic signed [DW-1:0] d;
  logic signed [SW-1:0] s;
  logic [SW-1:0]        mag;
  logic [IDXW-1:0]      idx_q;
  logic                 beat_hit, onset_hit, offset_hit, flat, c1, c2;

  function automatic logic [SW-1:0] mag_of(input logic signed [SW-1:0] v);
    return v[SW-1] ? SW'(-v) : SW'(v);
  endfunction

  assign mag = mag_of(s);

  slope_front #(.XW(XW), .AVG(AVG)) front_i (
    .clk(clk), .rst_n(rst_n), .vld(samp_vld), .x(samp), .d(d), .s(s));

  beat_gate #(.MW(SW), .DSH(DSH), .MIN_THR(MIN_THR), .REFRAC(REFRAC)) gate_i (
    .clk(clk), .rst_n(rst_n), .vld(samp_vld), .mag(mag), .hit(beat_hit));

  flat_finder #(.XW(XW), .FLATW(FLATW), .FLAT_LSB(FLAT_LSB)) flat_i (
    .clk(clk), .rst_n(rst_n), .vld(samp_vld), .x(samp), .flat(flat));

  onset_marker #(.DW(DW), .SW(SW), .IDXW(IDXW), .BIG(BIG), .HIGH(HIGH),
                 .W1(W1), .W2(W2)) mark_i (
    .clk(clk), .rst_n(rst_n), .vld(samp_vld), .d(d), .s(s), .idx(idx_q),
    .flat(flat), .c1(c1), .c2(c2), .onset_hit(onset_hit),
    .offset_hit(offset_hit));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q      <= '0;
      beat_stb   <= 1'b0;
      onset_stb  <= 1'b0;
      offset_stb <= 1'b0;
      beat_idx   <= '0;
      onset_idx  <= '0;
      offset_idx <= '0;
    end else begin
      beat_stb   <= beat_hit;
      onset_stb  <= onset_hit;
      offset_stb <= offset_hit;
      if (beat_hit)   beat_idx   <= idx_q;
      if (onset_hit)  onset_idx  <= idx_q;
      if (offset_hit) offset_idx <= idx_q;
      if (samp_vld)   idx_q      <= idx_q + IDXW'(1);
    end
  end

  // R10: every strobe follows an accepted sample
  a_r10_strobe_needs_vld: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_stb || onset_stb || offset_stb) |-> $past(samp_vld));
  // R5: refractory interval forbids beats on consecutive samples
  a_r5_beat_not_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    beat_stb |=> !beat_stb);
  // R8: an onset disarms the marker, so two onsets never follow each other
  a_r8_onset_not_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    onset_stb |=> !onset_stb);
  // R9: onset and offset never share a sample
  a_r9_marks_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(onset_stb && offset_stb));
  // R6: an onset is always caused by one of the two slope rules
  a_r6_onset_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    onset_stb |-> $past(c1 || c2));
endmodule

// File: tb/slope_beat_detector_tb_top.sv
`timescale 1ns/1ps
module slope_beat_detector_tb_top;
  localparam int XW = 12, AVG = 8, IDXW = 12, DSH = 3, MIN_THR = 40, REFRAC = 10;
  localparam int BIG = 60, W1 = 6, HIGH = 150, W2 = 20, FLATW = 8, FLAT_LSB = 5;
  localparam int MAXS = 3000;

  logic clk = 1'b0, rst_n = 1'b0, samp_vld = 1'b0;
  logic [XW-1:0] samp = '0;
  logic beat_stb, onset_stb, offset_stb;
  logic [IDXW-1:0] beat_idx, onset_idx, offset_idx;

  always #2 clk = ~clk;

  slope_beat_detector #(.XW(XW), .AVG(AVG), .IDXW(IDXW), .DSH(DSH),
    .MIN_THR(MIN_THR), .REFRAC(REFRAC), .BIG(BIG), .W1(W1), .HIGH(HIGH),
    .W2(W2), .FLATW(FLATW), .FLAT_LSB(FLAT_LSB)) dut_i (
    .clk(clk), .rst_n(rst_n), .samp_vld(samp_vld), .samp(samp),
    .beat_stb(beat_stb), .beat_idx(beat_idx), .onset_stb(onset_stb),
    .onset_idx(onset_idx), .offset_stb(offset_stb), .offset_idx(offset_idx));

  int total = 0, bad = 0;
  bit finished = 0;
  int xs [MAXS];
  int ns = 0, cur = 2000;
  logic [15:0] lfsr = 16'hACE1;

  // reference state
  int pk = 0, last_beat = -1, lb_idx = -1, lb_neg = 0, lp = -1, ln = -1;
  bit armed = 1;
  int n_beat = 0, n_block = 0, n_decay = 0, n_c1 = 0, n_c2 = 0, n_supp = 0;
  int n_off = 0, n_eq = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic int rnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return int'(lfsr);
  endfunction

  task automatic put(input int v);
    if (v < 0) v = 0;
    if (v > 4095) v = 4095;
    cur = v;
    if (ns < MAXS) begin xs[ns] = v; ns++; end
  endtask
  task automatic add_flat(input int len);
    for (int i = 0; i < len; i++) put(cur);
  endtask
  task automatic add_quiet(input int len);
    int base = cur;
    for (int i = 0; i < len; i++) begin put(base + (rnd() % 3) - 1); end
    cur = base;
  endtask
  task automatic add_ramp(input int len, input int stp);
    for (int i = 0; i < len; i++) put(cur + stp);
  endtask
  task automatic add_noise(input int len, input int amp);
    int base = cur;
    for (int i = 0; i < len; i++) put(base + (rnd() % (2*amp+1)) - amp);
    cur = base;
  endtask

  function automatic int dval(input int n);
    if (n < 0) return 0;
    return xs[n] - ((n > 0) ? xs[n-1] : 0);
  endfunction
  function automatic int sval(input int n);
    int acc = 0;
    for (int k = 0; k < AVG; k++) acc += dval(n - k);
    return acc;
  endfunction
  function automatic bit flat_at(input int n);
    int hi, lo;
    if (n < FLATW - 1) return 0;
    hi = xs[n]; lo = xs[n];
    for (int k = 1; k < FLATW; k++) begin
      if (xs[n-k] > hi) hi = xs[n-k];
      if (xs[n-k] < lo) lo = xs[n-k];
    end
    return (hi - lo) < FLAT_LSB;
  endfunction

  task automatic model(input int n, output bit eb, output bit eo, output bit ef);
    int s, d, mg, thr, dec, sg;
    bit big, c1, c2, free;
    s = sval(n); d = dval(n);
    mg = (s < 0) ? -s : s;
    thr = pk / 2;
    free = (last_beat < 0) || (n - last_beat > REFRAC);
    eb = free && thr >= MIN_THR && mg >= thr;
    if (!free && thr >= MIN_THR && mg >= thr) n_block++;
    if (eb) begin n_beat++; last_beat = n; if (mg == thr) n_eq++; end
    dec = pk - pk / (1 << DSH);
    if (dec < pk) n_decay++;
    pk = (mg > dec) ? mg : dec;
    big = (d >= BIG) || (d <= -BIG);
    sg = (d < 0);
    c1 = big && lb_idx >= 0 && lb_neg == sg && (n - lb_idx) < W1;
    if (big) begin lb_idx = n; lb_neg = sg; end
    c2 = 0;
    if (s >= HIGH)  c2 = ln >= 0 && (n - ln) < W2;
    if (s <= -HIGH) c2 = lp >= 0 && (n - lp) < W2;
    if (s >= HIGH)  lp = n;
    if (s <= -HIGH) ln = n;
    eo = armed && (c1 || c2);
    ef = !armed && flat_at(n);
    if (eo && c1) n_c1++;
    if (eo && c2 && !c1) n_c2++;
    if (!armed && (c1 || c2)) n_supp++;
    if (ef) n_off++;
    if (eo) armed = 0; else if (ef) armed = 1;
  endtask

  task automatic check_idle(input string req);
    check(!beat_stb && !onset_stb && !offset_stb, req, "strobe while idle",
          {beat_stb, onset_stb, offset_stb}, 0);
  endtask

  initial begin
    int sv_bidx;
    bit eb, eo, ef;
    // stimulus
    add_flat(30);
    for (int k = 0; k < 6; k++) begin
      add_ramp(6, 20 + 15*k); add_ramp(6, -(20 + 15*k)); add_quiet(40);
    end
    for (int g = 4; g <= 8; g++) begin
      add_ramp(1, 70); add_flat(g - 1); add_ramp(1, 70); add_quiet(30);
      add_ramp(1, -70); add_flat(g - 1); add_ramp(1, -70); add_quiet(30);
    end
    for (int g = 2; g <= 28; g += 3) begin
      add_ramp(16, 25); add_flat(g); add_ramp(16, -25); add_quiet(40);
    end
    add_noise(200, 120); add_quiet(40);
    for (int k = 0; k < 8; k++) begin
      add_ramp(4, 2 + k); add_ramp(4, -(2 + k)); add_quiet(20);
    end
    for (int k = 0; k < 10; k++) begin
      add_ramp(3, 40 + 7*k); add_ramp(3, -(40 + 7*k)); add_flat(k); add_noise(8, 3);
    end
    add_noise(300, 40); add_quiet(60);

    // R1: reset state
    repeat (5) @(negedge clk);
    check_idle("R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_idle("R1");

    sv_bidx = 0;
    for (int n = 0; n < ns; n++) begin
      samp = xs[n][XW-1:0];
      samp_vld = 1'b1;
      @(negedge clk);
      model(n, eb, eo, ef);
      check(beat_stb == eb, "R2 R3", $sformatf("beat at sample %0d", n), beat_stb, eb);
      if (eb) check(beat_idx == IDXW'(n), "R10", "beat index", beat_idx, n);
      check(onset_stb == eo, "R6 R7 R8", $sformatf("onset at sample %0d", n), onset_stb, eo);
      if (eo) check(onset_idx == IDXW'(n), "R10", "onset index", onset_idx, n);
      check(offset_stb == ef, "R9", $sformatf("offset at sample %0d", n), offset_stb, ef);
      if (ef) check(offset_idx == IDXW'(n), "R10", "offset index", offset_idx, n);
      if (n % 37 == 5) begin
        samp_vld = 1'b0;
        samp = 12'hFFF;
        @(negedge clk);
        check_idle("R10");
      end
    end
    samp_vld = 1'b0;
    @(negedge clk);
    check_idle("R10");

    // coverage of the boundary cases the requirements call out
    check(n_beat > 0,  "R3", "beats seen", n_beat, 1);
    check(n_decay > 0, "R4", "peak decay steps seen", n_decay, 1);
    check(n_block > 0, "R5", "refractory suppressions seen", n_block, 1);
    check(n_c1 > 0,    "R6", "step-rule onsets seen", n_c1, 1);
    check(n_c2 > 0,    "R7", "excursion-only onsets seen", n_c2, 1);
    check(n_supp > 0,  "R8", "ignored rule hits seen", n_supp, 1);
    check(n_off > 0,   "R9", "offsets seen", n_off, 1);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule